// File: doc/BRIEF.md
# CPU Processor-Status and Stack-Pointer Reset Unit

This block keeps the six architectural status flags of an 8-bit 6502-style CPU and the stack pointer's reset behaviour. The datapath drives per-flag update strobes, asks for the status byte to be stored when an instruction or interrupt saves the flags, and hands in a byte fetched from the stack when an instruction restores them. The unit builds the byte to store and applies the interrupt-mask side effects that go with each save source. It also tells the interrupt logic whether a maskable request may pass.

Two reset paths are provided. The synchronous power-up reset loads fixed flag and stack pointer values. A warm reset request starts a short sequence that sets the interrupt mask, leaves every other flag alone, and walks the stack pointer down by three without writing the stack. A small controller with two states, RUN and WARM, runs this sequence. The transition RUN to WARM is taken when `warm_rst` is high in RUN. The transition WARM to RUN is taken on the edge that applies the last stack-pointer step. While in WARM, all flag requests are dropped.

The decimal flag is stored, saved and restored like the others. It does not feed any logic in this unit.

Top module: `cpu_status_unit`

## Requirements
- R1: After power-up reset the flags N,V,D,Z,C read 0, I reads 1, the stack pointer reads $FD, and a save tagged PHP yields the byte $34.
- R2: The saved byte carries, from bit 7 down to bit 0: N, V, a constant 1, the source bit, D, I, Z, C. Bit 5 is always 1.
- R3: Save sources are coded on `push_src` as PHP=0, BRK=1, IRQ=2, NMI=3. Bit 4 of the saved byte is 1 for PHP and BRK and 0 for IRQ and NMI.
- R4: A save tagged BRK, IRQ or NMI sets I on the following clock edge. A save tagged PHP leaves I unchanged.
- R5: A restore loads N, V, D, I, Z, C from bits 7, 6, 3, 2, 1, 0 of `pull_byte` on the next edge. Bits 5 and 4 have no effect.
- R6: Each flag has its own enable on `flag_we`/`flag_wd` with bit order [5]=N, [4]=V, [3]=D, [2]=I, [1]=Z, [0]=C. A flag whose enable is low keeps its value.
- R7: D is stored and appears in the saved byte, but its value does not change `int_pend` or `irq_mask`.
- R8: `irq_mask` equals I. `int_pend` is high when `nmi_line` is high, or when `irq_line` is high and I is 0.
- R9: A warm reset in RUN sets I on that edge and leaves the other flags unchanged. On each of the next three edges the stack pointer drops by one, after which the unit is back in RUN. Flag requests and further `warm_rst` pulses are ignored during the sequence.
- R10: A save and a restore requested in the same cycle are rejected: no flag changes on that edge, including flags named by `flag_we`.
- R11: A restore overrides `flag_we` writes in the same cycle. The I-set of an interrupt or BRK save wins over a `flag_we` write to I in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| warm_rst | input | 1 | Warm reset request |
| flag_we | input | 6 | Per-flag write enables (N,V,D,I,Z,C) |
| flag_wd | input | 6 | Per-flag write values, same order |
| pull_req | input | 1 | Restore flags from `pull_byte` |
| pull_byte | input | 8 | Byte read from the stack |
| push_req | input | 1 | Flags are being saved |
| push_src | input | 2 | Save source: PHP, BRK, IRQ, NMI |
| irq_line | input | 1 | Maskable interrupt request, active high |
| nmi_line | input | 1 | Non-maskable interrupt request, active high |
| flags | output | 6 | Current flags N,V,D,I,Z,C |
| irq_mask | output | 1 | High while maskable interrupts are blocked |
| int_pend | output | 1 | An interrupt may be taken |
| push_byte | output | 8 | Byte to write to the stack |
| sp | output | 8 | Stack pointer |

## Verification
A wrong flag bit shows up at `flags` and in `push_byte` one edge after the request that produced it. A wrong I also changes `int_pend` in that same cycle, so the fault can be seen from the interrupt side. A controller stuck in WARM or leaving it early shows up as a stack pointer that stops one step short, overshoots, or keeps dropping. It also shows up as flag requests that are ignored in RUN, or obeyed inside the sequence. All of these are visible within four edges of the warm reset request.

// File: rtl/cpu_sr_pkg.sv
package cpu_sr_pkg;

    localparam int NFLAGS = 6;

    // Index of each flag inside the 6-bit flag vector
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_I = 2;
    localparam int FLG_D = 3;
    localparam int FLG_V = 4;
    localparam int FLG_N = 5;

    // Fixed bits of the saved byte
    localparam int BYTE_ONE = 5;
    localparam int BYTE_SRC = 4;

    typedef enum logic [1:0] {
        SRC_PHP = 2'd0,
        SRC_BRK = 2'd1,
        SRC_IRQ = 2'd2,
        SRC_NMI = 2'd3
    } push_src_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WARM = 1'b1
    } sr_state_e;

    // Position of a flag inside the saved/restored byte
    function automatic int flag_bitpos(input int idx);
        return (idx >= FLG_V) ? idx + 2 : idx;
    endfunction

    // Software-initiated saves mark bit 4; line-driven ones clear it
    function automatic logic src_is_soft(input push_src_e s);
        return (s == SRC_PHP) || (s == SRC_BRK);
    endfunction

endpackage

// File: rtl/cpu_sr_ctrl.sv
module cpu_sr_ctrl
    import cpu_sr_pkg::*;
#(
    parameter int WARM_STEPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic warm_rst,
    output logic in_run,
    output logic warm_start,
    output logic sp_step
);

    localparam int CW = (WARM_STEPS < 2) ? 1 : $clog2(WARM_STEPS);
    localparam logic [CW-1:0] LAST_STEP = CW'(WARM_STEPS - 1);

    sr_state_e       state_q;
    logic [CW-1:0]   step_q;

    // State register with step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            step_q  <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (warm_rst) begin
                        state_q <= ST_WARM;
                        step_q  <= '0;
                    end
                end
                ST_WARM: begin
                    if (step_q == LAST_STEP) begin
                        state_q <= ST_RUN;
                        step_q  <= '0;
                    end else begin
                        step_q  <= step_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_RUN;
                    step_q  <= '0;
                end
            endcase
        end
    end

    // Decoded outputs
    always_comb begin
        in_run     = 1'b0;
        warm_start = 1'b0;
        sp_step    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                in_run     = 1'b1;
                warm_start = warm_rst;
            end
            ST_WARM: begin
                sp_step    = 1'b1;
            end
            default: begin
                in_run     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cpu_sr_flags.sv
module cpu_sr_flags
    import cpu_sr_pkg::*;
#(
    parameter logic [NFLAGS-1:0] PWR_FLAGS = 6'b000100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_run,
    input  logic              warm_start,
    input  logic [NFLAGS-1:0] flag_we,
    input  logic [NFLAGS-1:0] flag_wd,
    input  logic              pull_req,
    input  logic [7:0]        pull_byte,
    input  logic              push_req,
    input  push_src_e         push_src,
    output logic [NFLAGS-1:0] flags_q
);

    logic [NFLAGS-1:0] alu_merged;
    logic [NFLAGS-1:0] pulled;
    logic [NFLAGS-1:0] flags_d;
    logic              clash;
    logic              sets_mask;

    // Per-flag merge of datapath writes and unpack of the restored byte
    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        assign alu_merged[g] = flag_we[g] ? flag_wd[g] : flags_q[g];
        assign pulled[g]     = pull_byte[flag_bitpos(g)];
    end

    assign clash     = push_req && pull_req;
    assign sets_mask = push_req && (push_src != SRC_PHP);

    always_comb begin
        flags_d = flags_q;
        if (warm_start) begin
            flags_d[FLG_I] = 1'b1;
        end else if (in_run && !clash) begin
            if (pull_req) begin
                flags_d = pulled;
            end else begin
                flags_d = alu_merged;
                if (sets_mask) begin
                    flags_d[FLG_I] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= PWR_FLAGS;
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/cpu_sr_stkptr.sv
module cpu_sr_stkptr #(
    parameter int              SP_W    = 8,
    parameter logic [SP_W-1:0] SP_INIT = 8'hFD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sp_step,
    output logic [SP_W-1:0] sp_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_INIT;
        end else if (sp_step) begin
            sp_q <= sp_q - 1'b1;
        end
    end

endmodule

// File: rtl/cpu_sr_pushfmt.sv
module cpu_sr_pushfmt
    import cpu_sr_pkg::*;
(
    input  logic [NFLAGS-1:0] flags_q,
    input  push_src_e         push_src,
    input  logic              irq_line,
    input  logic              nmi_line,
    output logic [7:0]        push_byte,
    output logic              irq_mask,
    output logic              int_pend
);

    always_comb begin
        push_byte = '0;
        for (int i = 0; i < NFLAGS; i++) begin
            push_byte[flag_bitpos(i)] = flags_q[i];
        end
        push_byte[BYTE_ONE] = 1'b1;
        push_byte[BYTE_SRC] = src_is_soft(push_src);
    end

    assign irq_mask = flags_q[FLG_I];
    assign int_pend = nmi_line || (irq_line && !flags_q[FLG_I]);

endmodule

// File: rtl/cpu_status_unit.sv
module cpu_status_unit
    import cpu_sr_pkg::*;
#(
    parameter int              SP_W       = 8,
    parameter logic [SP_W-1:0] SP_INIT    = 8'hFD,
    parameter int              WARM_STEPS = 3,
    parameter logic [5:0]      PWR_FLAGS  = 6'b000100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            warm_rst,
    input  logic [5:0]      flag_we,
    input  logic [5:0]      flag_wd,
    input  logic            pull_req,
    input  logic [7:0]      pull_byte,
    input  logic            push_req,
    input  logic [1:0]      push_src,
    input  logic            irq_line,
    input  logic            nmi_line,
    output logic [5:0]      flags,
    output logic            irq_mask,
    output logic            int_pend,
    output logic [7:0]      push_byte,
    output logic [SP_W-1:0] sp
);

    logic      in_run;
    logic      warm_start;
    logic      sp_step;
    push_src_e src_e;

    assign src_e = push_src_e'(push_src);

    cpu_sr_ctrl #(
        .WARM_STEPS (WARM_STEPS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .warm_rst   (warm_rst),
        .in_run     (in_run),
        .warm_start (warm_start),
        .sp_step    (sp_step)
    );

    cpu_sr_flags #(
        .PWR_FLAGS (PWR_FLAGS)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_run     (in_run),
        .warm_start (warm_start),
        .flag_we    (flag_we),
        .flag_wd    (flag_wd),
        .pull_req   (pull_req),
        .pull_byte  (pull_byte),
        .push_req   (push_req),
        .push_src   (src_e),
        .flags_q    (flags)
    );

    cpu_sr_stkptr #(
        .SP_W    (SP_W),
        .SP_INIT (SP_INIT)
    ) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sp_step (sp_step),
        .sp_q    (sp)
    );

    cpu_sr_pushfmt u_fmt (
        .flags_q   (flags),
        .push_src  (src_e),
        .irq_line  (irq_line),
        .nmi_line  (nmi_line),
        .push_byte (push_byte),
        .irq_mask  (irq_mask),
        .int_pend  (int_pend)
    );

endmodule

// File: rtl/cpu_status_unit_chk.sv
module cpu_status_unit_chk #(
    parameter int SP_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            warm_rst,
    input logic            pull_req,
    input logic            push_req,
    input logic [1:0]      push_src,
    input logic            irq_line,
    input logic            nmi_line,
    input logic            in_run,
    input logic [5:0]      flags,
    input logic            int_pend,
    input logic [7:0]      push_byte,
    input logic [SP_W-1:0] sp
);

    p_bit5_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> push_byte[5]);

    p_src_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> (push_byte[4] == !push_src[1]));

    p_mask_on_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && push_req && !pull_req && !warm_rst && push_src != 2'd0)
        |=> flags[2]);

    p_irq_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line && !nmi_line && flags[2]) |-> !int_pend);

    p_nmi_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_line |-> int_pend);

    p_warm_sp_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_run |=> (sp == $past(sp) - 1'b1));

    p_warm_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_run |=> $stable(flags));

    p_clash_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && push_req && pull_req && !warm_rst) |=> $stable(flags));

endmodule

bind cpu_status_unit cpu_status_unit_chk #(.SP_W(SP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_rst  (warm_rst),
    .pull_req  (pull_req),
    .push_req  (push_req),
    .push_src  (push_src),
    .irq_line  (irq_line),
    .nmi_line  (nmi_line),
    .in_run    (in_run),
    .flags     (flags),
    .int_pend  (int_pend),
    .push_byte (push_byte),
    .sp        (sp)
);

// File: tb/sim_cpu_status_unit.sv
module sim_cpu_status_unit;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       warm_rst = 1'b0;
    logic [5:0] flag_we = '0;
    logic [5:0] flag_wd = '0;
    logic       pull_req = 1'b0;
    logic [7:0] pull_byte = '0;
    logic       push_req = 1'b0;
    logic [1:0] push_src = '0;
    logic       irq_line = 1'b0;
    logic       nmi_line = 1'b0;
    logic [5:0] flags;
    logic       irq_mask;
    logic       int_pend;
    logic [7:0] push_byte;
    logic [7:0] sp;

    typedef struct {
        logic [5:0] f;
        logic [7:0] s;
        logic [7:0] pb;
        logic       ip;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run = 0;
    int   n_fail = 0;
    logic done = 1'b0;

    // Reference state built from the requirements
    logic [5:0] m_f;
    logic [7:0] m_sp;
    int         m_warm;

    always #(CLK_P/2) clk = ~clk;

    cpu_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .flag_we(flag_we), .flag_wd(flag_wd),
        .pull_req(pull_req), .pull_byte(pull_byte),
        .push_req(push_req), .push_src(push_src),
        .irq_line(irq_line), .nmi_line(nmi_line),
        .flags(flags), .irq_mask(irq_mask), .int_pend(int_pend),
        .push_byte(push_byte), .sp(sp)
    );

    function automatic logic [7:0] pack(input logic [5:0] f, input logic [1:0] src);
        return {f[5], f[4], 1'b1, (src < 2'd2), f[3], f[2], f[1], f[0]};
    endfunction

    task automatic drive(input logic [5:0] we, input logic [5:0] wd,
                         input logic pl, input logic [7:0] pbyte,
                         input logic ps, input logic [1:0] src,
                         input logic irq, input logic nmi, input logic wr,
                         input string tag);
        exp_t e;
        @(negedge clk);
        flag_we = we; flag_wd = wd; pull_req = pl; pull_byte = pbyte;
        push_req = ps; push_src = src; irq_line = irq; nmi_line = nmi;
        warm_rst = wr;
        if (m_warm > 0) begin
            m_sp = m_sp - 8'd1;
            m_warm--;
        end else if (wr) begin
            m_f[2] = 1'b1;
            m_warm = 3;
        end else if (ps && pl) begin
            m_f = m_f;
        end else if (pl) begin
            m_f = {pbyte[7], pbyte[6], pbyte[3], pbyte[2], pbyte[1], pbyte[0]};
        end else begin
            for (int i = 0; i < 6; i++) if (we[i]) m_f[i] = wd[i];
            if (ps && src != 2'd0) m_f[2] = 1'b1;
        end
        e.f = m_f; e.s = m_sp; e.pb = pack(m_f, src);
        e.ip = nmi || (irq && !m_f[2]); e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare a quarter period after each active edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (flags !== e.f || sp !== e.s || push_byte !== e.pb ||
                int_pend !== e.ip || irq_mask !== e.f[2]) begin
                n_fail++;
                $display("FAIL %s: flags=%b sp=%h pb=%h ip=%b mask=%b exp flags=%b sp=%h pb=%h ip=%b mask=%b",
                         e.tag, flags, sp, push_byte, int_pend, irq_mask,
                         e.f, e.s, e.pb, e.ip, e.f[2]);
            end
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_f = 6'b000100; m_sp = 8'hFD; m_warm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: power-up values, PHP save reads $34
        drive(6'h00, 6'h00, 0, 8'h00, 1, 2'd0, 0, 0, 0, "R1");
        // R6: clear only I; R8: irq now passes
        drive(6'b000100, 6'h00, 0, 8'h00, 0, 2'd0, 1, 0, 0, "R6 R8");
        // R4: PHP keeps I clear
        drive(6'h00, 6'h00, 0, 8'h00, 1, 2'd0, 1, 0, 0, "R4");
        // R4 R3: IRQ save sets I, bit4 clear; R8 irq now blocked
        drive(6'h00, 6'h00, 0, 8'h00, 1, 2'd2, 1, 0, 0, "R3 R4 R8");
        // R8: nmi passes while masked
        drive(6'h00, 6'h00, 0, 8'h00, 0, 2'd0, 1, 1, 0, "R8");
        // R6: write all flags; R2 layout with BRK tag
        drive(6'h3F, 6'b110011, 0, 8'h00, 0, 2'd1, 0, 0, 0, "R6 R2");
        // R6: partial write keeps N and V
        drive(6'b000011, 6'b000010, 0, 8'h00, 0, 2'd0, 0, 0, 0, "R6");
        // R5: restore, bits 5/4 of 0x0D are zero and ignored
        drive(6'h00, 6'h00, 1, 8'h0D, 0, 2'd0, 0, 0, 0, "R5");
        // R5: restore 0xF0, bits 5/4 set but ignored; R3 NMI tag
        drive(6'h00, 6'h00, 1, 8'hF0, 0, 2'd3, 0, 0, 0, "R5 R3");
        // R11: restore wins over datapath write of C
        drive(6'b000001, 6'b000001, 1, 8'h00, 0, 2'd0, 0, 0, 0, "R11");
        // R11: NMI save I-set wins over a write clearing I
        drive(6'b000101, 6'b000001, 0, 8'h00, 1, 2'd3, 0, 0, 0, "R11");
        // R10: save and restore together are rejected
        drive(6'h3F, 6'h00, 1, 8'hFF, 1, 2'd1, 0, 0, 0, "R10");
        // R7: set D, irq still masked by I
        drive(6'b001000, 6'b001000, 0, 8'h00, 0, 2'd0, 1, 0, 0, "R7");
        // R7: clear I with D set, irq passes
        drive(6'b000100, 6'h00, 0, 8'h00, 0, 2'd0, 1, 0, 0, "R7");
        // R9: warm reset sets I, concurrent requests dropped
        drive(6'h3F, 6'h00, 1, 8'h00, 1, 2'd2, 0, 0, 1, "R9");
        drive(6'h3F, 6'h00, 0, 8'h00, 0, 2'd0, 0, 0, 0, "R9");
        drive(6'h00, 6'h00, 1, 8'h00, 0, 2'd0, 0, 0, 1, "R9");
        drive(6'h00, 6'h00, 0, 8'h00, 1, 2'd1, 0, 0, 0, "R9");
        drive(6'h00, 6'h00, 0, 8'h00, 0, 2'd0, 0, 0, 0, "R9");
        // R9: back in RUN, requests obeyed again
        drive(6'b000100, 6'h00, 0, 8'h00, 0, 2'd0, 1, 0, 0, "R9 R6");
        drive(6'h00, 6'h00, 0, 8'h00, 0, 2'd0, 0, 0, 0, "R9");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule